// File: doc/BRIEF.md
# Configurable Multi-Source Interrupt Controller

This block gathers interrupt requests from thirty-two independent sources. It turns them into two prioritised request lines and one wake line. Each source has its own trigger mode: off, rising edge, falling edge, both edges, active-high level or active-low level. Inputs are synchronised before any trigger logic sees them. Edge events are latched in sticky capture registers until software clears them. Level events follow the synchronised input directly.

Software reaches every control register through a small word-addressed register port. A register address is made of a 4-bit group index and a 2-bit operation code. The operation code selects one of three access types: read-back, write-1-to-set or write-1-to-clear. Software can therefore change one source without a read-modify-write. A per-source route bit steers a pending source to the high-priority line or to the low-priority line. Two status reads show which sources are pending on each line.

Top module: `irqc_top`

## Requirements
- R1: After reset all configuration planes are 0, and so are the mask, wake, route, source-select and test registers and both capture registers. All three outputs are low.
- R2: The register address is {group[3:0], op[1:0]}. The op codes are: 0 reads, 1 sets, 2 clears. The groups are: 0 cfg0, 1 cfg1, 2 cfg2, 3 mask, 4 wake, 5 route, 6 source-select, 7 test, 8 rising capture, 9 falling capture, 10 status of request 0, 11 status of request 1. A read of groups 0 to 7 returns the stored value.
- R3: On a set or clear access, each 1 in wr_data sets or clears the same bit of the register. Bits written as 0 keep their value.
- R4: The mode of source i is {cfg2[i],cfg1[i],cfg0[i]}. In mode 001 a 0-to-1 change of the input sets bit i of the rising capture. In mode 010 a 1-to-0 change sets bit i of the falling capture. Mode 011 captures both changes. A capture bit stays set until a 1 is written to its bit at the clear address of its own group.
- R5: In mode 101 a source is active while its synchronised input is 1. In mode 110 it is active while the input is 0. Nothing is latched in these modes.
- R6: Mode 000 and the unused codes 100 and 111 never make a source pending, whatever the input does.
- R7: A source is pending only while its mask bit is 1. A masked source still records its edges, so setting the mask later raises the request.
- R8: A pending source with route bit 1 appears in status group 10 and drives irq_req0. A pending source with route bit 0 appears in status group 11 and drives irq_req1.
- R9: irq_wake is high exactly when some pending source has its wake bit set.
- R10: The source-select and test registers read back what was written and have no effect on any output.
- R11: Inputs pass through two flops. A level change driven just after edge k shows at the outputs after edge k+2. An edge capture shows after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Raw interrupt source inputs |
| addr | input | 6 | Register address {group, op} |
| wr_en | input | 1 | Write strobe |
| wr_data | input | NSRC | Write data, one bit per source |
| rd_data | output | NSRC | Read data for the addressed group (combinational) |
| irq_req0 | output | 1 | High-priority request line |
| irq_req1 | output | 1 | Low-priority request line |
| irq_wake | output | 1 | Wake request |

## Verification
The bench builds the controller with its default NSRC of 32. With that width, sources at bit 0, in the middle and at bit 31 can all be driven, so the top bit of every set, clear and capture path is covered. Each of the six defined trigger codes is exercised, and so are both unused codes. The exact two- and three-edge latencies through the synchroniser are checked, as are masked edge capture and routing to both request lines.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int GRP_W  = 4;
    localparam int OP_W   = 2;
    localparam int ADDR_W = GRP_W + OP_W;
    localparam int NCTRL  = 8;   // set/clear registers, groups 0..7

    typedef enum logic [GRP_W-1:0] {
        G_CFG0   = 4'd0,
        G_CFG1   = 4'd1,
        G_CFG2   = 4'd2,
        G_MASK   = 4'd3,
        G_WAKE   = 4'd4,
        G_ROUTE  = 4'd5,
        G_SRCSEL = 4'd6,
        G_TEST   = 4'd7,
        G_RISE   = 4'd8,
        G_FALL   = 4'd9,
        G_STAT0  = 4'd10,
        G_STAT1  = 4'd11
    } grp_e;

    typedef enum logic [OP_W-1:0] {
        OP_READ = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2
    } op_e;

    typedef struct packed {
        logic wr;
        grp_e grp;
        op_e  op;
    } bus_dec_t;

    function automatic logic [ADDR_W-1:0] reg_addr(grp_e g, op_e o);
        return {g, o};
    endfunction

    function automatic bus_dec_t decode(logic [ADDR_W-1:0] a, logic w);
        bus_dec_t d;
        d.wr  = w;
        d.grp = grp_e'(a[ADDR_W-1:OP_W]);
        d.op  = op_e'(a[OP_W-1:0]);
        return d;
    endfunction

    // Trigger mode classification on {cfg2,cfg1,cfg0}
    function automatic logic catches_rise(logic [2:0] m);
        return (m == 3'b001) || (m == 3'b011);
    endfunction

    function automatic logic catches_fall(logic [2:0] m);
        return (m == 3'b010) || (m == 3'b011);
    endfunction

    function automatic logic level_high(logic [2:0] m);
        return m == 3'b101;
    endfunction

    function automatic logic level_low(logic [2:0] m);
        return m == 3'b110;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_dly
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
            q_dly  <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
            q_dly  <= q;
        end
    end
endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs
    import irqc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  bus_dec_t                   dec,
    input  logic [NSRC-1:0]            wdata,
    output logic [NCTRL-1:0][NSRC-1:0] ctrl_q
);
    for (genvar g = 0; g < NCTRL; g++) begin : g_reg
        logic hit;
        assign hit = dec.wr && (dec.grp == grp_e'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[g] <= '0;
            end else if (hit && dec.op == OP_SET) begin
                ctrl_q[g] <= ctrl_q[g] | wdata;
            end else if (hit && dec.op == OP_CLR) begin
                ctrl_q[g] <= ctrl_q[g] & ~wdata;
            end
        end
    end
endmodule

// File: rtl/irqc_trigger.sv
module irqc_trigger
    import irqc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] lvl,
    input  logic [NSRC-1:0] lvl_dly,
    input  logic [NSRC-1:0] cfg0,
    input  logic [NSRC-1:0] cfg1,
    input  logic [NSRC-1:0] cfg2,
    input  logic [NSRC-1:0] mask,
    input  logic [NSRC-1:0] rise_clr,
    input  logic [NSRC-1:0] fall_clr,
    output logic [NSRC-1:0] rise_cap,
    output logic [NSRC-1:0] fall_cap,
    output logic [NSRC-1:0] pending
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [2:0] mode;
        logic       rise_ev, fall_ev;
        logic       rc_q, fc_q;
        logic       active;

        assign mode    = {cfg2[i], cfg1[i], cfg0[i]};
        assign rise_ev = lvl[i] & ~lvl_dly[i];
        assign fall_ev = ~lvl[i] & lvl_dly[i];

        // A new event wins over a clear in the same cycle
        always_ff @(posedge clk) begin
            if (rst) begin
                rc_q <= 1'b0;
                fc_q <= 1'b0;
            end else begin
                rc_q <= (catches_rise(mode) & rise_ev) | (rc_q & ~rise_clr[i]);
                fc_q <= (catches_fall(mode) & fall_ev) | (fc_q & ~fall_clr[i]);
            end
        end

        always_comb begin
            if (catches_rise(mode) || catches_fall(mode))
                active = rc_q | fc_q;
            else if (level_high(mode))
                active = lvl[i];
            else if (level_low(mode))
                active = ~lvl[i];
            else
                active = 1'b0;
        end

        assign rise_cap[i] = rc_q;
        assign fall_cap[i] = fc_q;
        assign pending[i]  = mask[i] & active;
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [NSRC-1:0]   wr_data,
    output logic [NSRC-1:0]   rd_data,
    output logic              irq_req0,
    output logic              irq_req1,
    output logic              irq_wake
);
    bus_dec_t                   dec;
    logic [NCTRL-1:0][NSRC-1:0] ctrl_q;
    logic [NSRC-1:0]            lvl, lvl_dly;
    logic [NSRC-1:0]            cfg0_q, cfg1_q, cfg2_q, mask_q, wake_q, route_q;
    logic [NSRC-1:0]            rise_clr, fall_clr;
    logic [NSRC-1:0]            rise_cap, fall_cap, pending;
    logic [NSRC-1:0]            stat0, stat1;

    assign dec = decode(addr, wr_en);

    irqc_ctrl_regs #(.NSRC(NSRC)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .dec    (dec),
        .wdata  (wr_data),
        .ctrl_q (ctrl_q)
    );

    assign cfg0_q  = ctrl_q[G_CFG0];
    assign cfg1_q  = ctrl_q[G_CFG1];
    assign cfg2_q  = ctrl_q[G_CFG2];
    assign mask_q  = ctrl_q[G_MASK];
    assign wake_q  = ctrl_q[G_WAKE];
    assign route_q = ctrl_q[G_ROUTE];

    irqc_sync #(.W(NSRC)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d     (src_in),
        .q     (lvl),
        .q_dly (lvl_dly)
    );

    assign rise_clr = (dec.wr && dec.grp == G_RISE && dec.op == OP_CLR) ? wr_data : '0;
    assign fall_clr = (dec.wr && dec.grp == G_FALL && dec.op == OP_CLR) ? wr_data : '0;

    irqc_trigger #(.NSRC(NSRC)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl),
        .lvl_dly  (lvl_dly),
        .cfg0     (cfg0_q),
        .cfg1     (cfg1_q),
        .cfg2     (cfg2_q),
        .mask     (mask_q),
        .rise_clr (rise_clr),
        .fall_clr (fall_clr),
        .rise_cap (rise_cap),
        .fall_cap (fall_cap),
        .pending  (pending)
    );

    assign stat0    = pending & route_q;
    assign stat1    = pending & ~route_q;
    assign irq_req0 = |stat0;
    assign irq_req1 = |stat1;
    assign irq_wake = |(pending & wake_q);

    always_comb begin
        rd_data = '0;
        if (dec.op == OP_READ) begin
            case (dec.grp)
                G_CFG0, G_CFG1, G_CFG2, G_MASK,
                G_WAKE, G_ROUTE, G_SRCSEL, G_TEST: rd_data = ctrl_q[dec.grp[2:0]];
                G_RISE:  rd_data = rise_cap;
                G_FALL:  rd_data = fall_cap;
                G_STAT0: rd_data = stat0;
                G_STAT1: rd_data = stat1;
                default: rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [NSRC-1:0]   wr_data,
    input logic [NSRC-1:0]   cfg0_q,
    input logic [NSRC-1:0]   cfg1_q,
    input logic [NSRC-1:0]   cfg2_q,
    input logic [NSRC-1:0]   mask_q,
    input logic [NSRC-1:0]   rise_cap,
    input logic [NSRC-1:0]   pending,
    input logic              irq_req0,
    input logic              irq_req1,
    input logic              irq_wake
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (mask_q == '0 && rise_cap == '0 && cfg0_q == '0));

    a_r3_set_alias: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == reg_addr(G_MASK, OP_SET))
        |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

    a_r3_clr_alias: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == reg_addr(G_MASK, OP_CLR))
        |=> ((mask_q & $past(wr_data)) == '0));

    a_r3_zero_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data == '0 &&
         (addr == reg_addr(G_MASK, OP_SET) || addr == reg_addr(G_MASK, OP_CLR)))
        |=> $stable(mask_q));

    a_r4_capture_sticky: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == reg_addr(G_RISE, OP_CLR))
        |=> (($past(rise_cap) & ~rise_cap) == '0));

    a_r6_off_silent: assert property (@(posedge clk) disable iff (rst)
        ((pending & ~(cfg0_q | cfg1_q | cfg2_q)) == '0));

    a_r7_mask_gate: assert property (@(posedge clk) disable iff (rst)
        ((pending & ~mask_q) == '0));

    a_r9_wake_needs_request: assert property (@(posedge clk) disable iff (rst)
        irq_wake |-> (irq_req0 || irq_req1));
endmodule

bind irqc_top irqc_checker #(.NSRC(NSRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cfg0_q   (cfg0_q),
    .cfg1_q   (cfg1_q),
    .cfg2_q   (cfg2_q),
    .mask_q   (mask_q),
    .rise_cap (rise_cap),
    .pending  (pending),
    .irq_req0 (irq_req0),
    .irq_req1 (irq_req1),
    .irq_wake (irq_wake)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
    import irqc_pkg::*;

    localparam int NSRC = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NSRC-1:0]   src_in = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [NSRC-1:0]   wr_data = '0;
    logic [NSRC-1:0]   rd_data;
    logic              irq_req0, irq_req1, irq_wake;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irqc_top #(.NSRC(NSRC)) dut (
        .clk      (clk),
        .rst      (rst),
        .src_in   (src_in),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .irq_req0 (irq_req0),
        .irq_req1 (irq_req1),
        .irq_wake (irq_wake)
    );

    task automatic chk(input string req, input string what,
                       input logic [NSRC-1:0] got, input logic [NSRC-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input grp_e g, input op_e o, input logic [NSRC-1:0] d);
        @(negedge clk);
        addr = reg_addr(g, o); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; addr = '0;
    endtask

    task automatic rd(input grp_e g, output logic [NSRC-1:0] v);
        addr = reg_addr(g, OP_READ);
        #1;
        v = rd_data;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input int idx, input logic [2:0] m);
        wr(G_CFG0, m[0] ? OP_SET : OP_CLR, NSRC'(1) << idx);
        wr(G_CFG1, m[1] ? OP_SET : OP_CLR, NSRC'(1) << idx);
        wr(G_CFG2, m[2] ? OP_SET : OP_CLR, NSRC'(1) << idx);
    endtask

    task automatic cleanup();
        for (int g = 0; g < NCTRL; g++) wr(grp_e'(g), OP_CLR, '1);
        src_in = '0;
        settle(4);
        wr(G_RISE, OP_CLR, '1);
        wr(G_FALL, OP_CLR, '1);
    endtask

    task automatic t_reset();
        logic [NSRC-1:0] v;
        for (int g = 0; g < 10; g++) begin
            rd(grp_e'(g), v);
            chk("R1", $sformatf("group %0d after reset", g), v, '0);
        end
        chk("R1", "outputs after reset", {irq_req0, irq_req1, irq_wake}, '0);
    endtask

    task automatic t_setclr();
        logic [NSRC-1:0] v, pat;
        for (int g = 0; g < NCTRL; g++) begin
            pat = 32'hA5C3_0F81 ^ (NSRC'(g) << 8);
            wr(grp_e'(g), OP_SET, pat);
            rd(grp_e'(g), v);
            chk("R2", $sformatf("readback group %0d", g), v, pat);
            wr(grp_e'(g), OP_SET, '0);
            wr(grp_e'(g), OP_CLR, '0);
            rd(grp_e'(g), v);
            chk("R3", "zero write keeps value", v, pat);
            wr(grp_e'(g), OP_CLR, 32'h8000_0001);
            rd(grp_e'(g), v);
            chk("R3", "partial clear", v, pat & ~32'h8000_0001);
            wr(grp_e'(g), OP_CLR, '1);
        end
    endtask

    task automatic t_rise();
        logic [NSRC-1:0] v;
        set_mode(3, 3'b001);
        wr(G_ROUTE, OP_SET, 32'h8);
        wr(G_MASK, OP_SET, 32'h8);
        src_in[3] = 1'b1;
        settle(2);
        chk("R11", "edge not yet captured", NSRC'(irq_req0), '0);
        settle(1);
        chk("R11", "edge captured after third edge", NSRC'(irq_req0), 1);
        rd(G_STAT0, v); chk("R8", "status0 rising src", v, 32'h8);
        rd(G_STAT1, v); chk("R8", "status1 empty", v, '0);
        src_in[3] = 1'b0;
        settle(4);
        chk("R4", "capture sticky after input falls", NSRC'(irq_req0), 1);
        rd(G_FALL, v); chk("R4", "rising mode ignores fall", v, '0);
        wr(G_RISE, OP_CLR, 32'h8);
        chk("R4", "capture cleared", NSRC'(irq_req0), '0);
        cleanup();
    endtask

    task automatic t_fall();
        logic [NSRC-1:0] v;
        src_in[7] = 1'b1;
        settle(4);
        set_mode(7, 3'b010);
        wr(G_MASK, OP_SET, 32'h80);
        settle(3);
        chk("R4", "falling mode idle while high", NSRC'(irq_req1), '0);
        src_in[7] = 1'b0;
        settle(4);
        chk("R8", "unrouted source on req1", NSRC'(irq_req1), 1);
        chk("R8", "req0 quiet", NSRC'(irq_req0), '0);
        rd(G_FALL, v); chk("R4", "falling capture", v, 32'h80);
        rd(G_RISE, v); chk("R4", "no rising capture", v, '0);
        wr(G_FALL, OP_CLR, 32'h80);
        chk("R4", "fall capture cleared", NSRC'(irq_req1), '0);
        cleanup();
    endtask

    task automatic t_both();
        logic [NSRC-1:0] v;
        set_mode(31, 3'b011);
        wr(G_ROUTE, OP_SET, 32'h8000_0000);
        wr(G_MASK, OP_SET, 32'h8000_0000);
        src_in[31] = 1'b1;
        settle(4);
        chk("R4", "both mode rising", NSRC'(irq_req0), 1);
        wr(G_RISE, OP_CLR, 32'h8000_0000);
        chk("R4", "both mode cleared", NSRC'(irq_req0), '0);
        src_in[31] = 1'b0;
        settle(4);
        chk("R4", "both mode falling", NSRC'(irq_req0), 1);
        rd(G_FALL, v); chk("R4", "bit 31 fall capture", v, 32'h8000_0000);
        cleanup();
    endtask

    task automatic t_level();
        logic [NSRC-1:0] v;
        set_mode(12, 3'b101);
        wr(G_MASK, OP_SET, 32'h1000);
        src_in[12] = 1'b1;
        settle(1);
        chk("R11", "level after one edge", NSRC'(irq_req1), '0);
        settle(1);
        chk("R11", "level after two edges", NSRC'(irq_req1), 1);
        src_in[12] = 1'b0;
        settle(3);
        chk("R5", "high level released", NSRC'(irq_req1), '0);
        set_mode(13, 3'b110);
        wr(G_MASK, OP_SET, 32'h2000);
        settle(1);
        rd(G_STAT1, v); chk("R5", "low level active", v, 32'h2000);
        src_in[13] = 1'b1;
        settle(3);
        chk("R5", "low level released", NSRC'(irq_req1), '0);
        rd(G_RISE, v); chk("R5", "level modes latch nothing", v, '0);
        cleanup();
    endtask

    task automatic t_off();
        logic [NSRC-1:0] v;
        logic [2:0] modes [3] = '{3'b000, 3'b100, 3'b111};
        wr(G_MASK, OP_SET, 32'h0010_0000);
        wr(G_ROUTE, OP_SET, 32'h0010_0000);
        foreach (modes[k]) begin
            set_mode(20, modes[k]);
            src_in[20] = 1'b1; settle(4);
            chk("R6", $sformatf("mode %b high", modes[k]), {irq_req0, irq_req1}, '0);
            src_in[20] = 1'b0; settle(4);
            chk("R6", $sformatf("mode %b low", modes[k]), {irq_req0, irq_req1}, '0);
            rd(G_RISE, v); chk("R6", "no capture", v, '0);
        end
        cleanup();
    endtask

    task automatic t_mask();
        logic [NSRC-1:0] v;
        set_mode(5, 3'b001);
        src_in[5] = 1'b1;
        settle(4);
        chk("R7", "masked edge silent", NSRC'(irq_req1), '0);
        rd(G_RISE, v); chk("R7", "masked edge recorded", v, 32'h20);
        wr(G_MASK, OP_SET, 32'h20);
        chk("R7", "unmask raises request", NSRC'(irq_req1), 1);
        cleanup();
    endtask

    task automatic t_wake();
        set_mode(9, 3'b101);
        wr(G_MASK, OP_SET, 32'h200);
        wr(G_WAKE, OP_SET, 32'h200);
        src_in[9] = 1'b1;
        settle(3);
        chk("R9", "wake with pending source", NSRC'(irq_wake), 1);
        wr(G_WAKE, OP_CLR, 32'h200);
        chk("R9", "wake bit cleared", NSRC'(irq_wake), '0);
        chk("R9", "request remains", NSRC'(irq_req1), 1);
        cleanup();
    endtask

    task automatic t_store();
        logic [NSRC-1:0] v;
        set_mode(2, 3'b101);
        wr(G_MASK, OP_SET, 32'h4);
        src_in[2] = 1'b1;
        settle(3);
        wr(G_SRCSEL, OP_SET, '1);
        wr(G_TEST, OP_SET, 32'h0000_00FF);
        settle(2);
        rd(G_SRCSEL, v); chk("R10", "source-select readback", v, '1);
        rd(G_TEST, v);   chk("R10", "test readback", v, 32'hFF);
        chk("R10", "outputs unaffected", {irq_req0, irq_req1, irq_wake}, 3'b010);
        rd(G_STAT1, v);  chk("R10", "status unaffected", v, 32'h4);
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_setclr();
        t_rise();
        t_fall();
        t_both();
        t_level();
        t_off();
        t_mask();
        t_wake();
        t_store();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule